// File: doc/BRIEF.md
# Prioritized Memory Protection Checker

This block judges each bus access against a set of up to sixteen programmable address regions and returns a verdict: allow, or raise a protection fault. Each region has an aligned power-of-two window, an enable bit, an eight-way subregion mask, a three-bit permission code, an execute-never flag and cache attribute bits that the block carries but does not interpret. Regions may overlap or nest. Where they do, the region with the higher number wins. A disabled subregion makes the address fall through to the next lower matching region, or to the background rule when no lower region matches.

Software programs the regions through a narrow write port. Each write selects a region, selects a target (base word, attribute word, or the global control word) and supplies the data. The access port accepts one request per cycle. Each request carries an address and three flags: privilege level, read or write, and data or instruction fetch. One cycle later the block returns the verdict, the index of the winning region and that region's full attribute word.

Top module: `mg_guard`

## Requirements
- R1: After reset, res_valid, res_allow, res_fault, res_hit, res_idx and res_attr are all zero. Every region is cleared. The global enable and the background enable are both 0, so an access made before any write is allowed.
- R2: While the global enable is 0, every access returns res_allow=1, res_fault=0 and res_hit=0, whatever the region contents.
- R3: When several enabled regions match an address, the one with the highest index decides the verdict and is reported.
- R4: A region covers 2^(SIZE+1) bytes starting at its base address masked to that alignment. A region with SIZE below 4 never matches, and neither does a region whose enable bit is 0. SIZE=31 covers the whole 32-bit space.
- R5: For SIZE of 7 or more, bit k of the subregion mask set to 1 removes the k-th eighth of the region, counted from the base. An address there is decided by the highest lower region that matches, or by the background rule.
- R6: For SIZE 4 to 6, the subregion mask has no effect.
- R7: Permission codes for data accesses, given as privileged/unprivileged: 000 none/none; 001 read-write/none; 010 read-write/read; 011 read-write/read-write; 101 read/none; 110 and 111 read/read. A data access outside these grants faults.
- R8: Permission code 100 faults every access.
- R9: An instruction fetch ignores the write flag. It is allowed only when the winning region grants read at the access's privilege level and the region's execute-never flag is 0.
- R10: When the global enable is 1 and no region matches, a privileged access is allowed if the background enable is 1. Every other such access faults, and res_hit is 0.
- R11: res_idx and res_attr carry the winning region's index and its 32-bit attribute word. The attribute word layout is: bit 0 enable, bits 5:1 SIZE, bits 13:6 subregion mask, bit 14 bufferable, bit 15 cacheable, bit 16 shareable, bits 19:17 type extension, bits 22:20 permission code, bit 23 execute-never. Both outputs are 0 when res_hit is 0.
- R12: The verdict for an access presented with acc_valid appears with res_valid exactly one cycle later. An access in the same cycle as a configuration write uses the old configuration. An access in the following cycle uses the new one.
- R13: Write port selector values: cfg_sel 0 writes the base address of region cfg_idx, 1 writes its attribute word, and 2 writes the control word (bit 0 global enable, bit 1 background enable). res_fault equals res_valid and not res_allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 base, 1 attribute, 2 control |
| cfg_idx | input | 4 | Region selected by the write |
| cfg_data | input | 32 | Write data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 = privileged access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch |
| res_valid | output | 1 | Verdict valid |
| res_allow | output | 1 | Access permitted |
| res_fault | output | 1 | Protection fault |
| res_hit | output | 1 | A region matched |
| res_idx | output | 4 | Winning region index |
| res_attr | output | 32 | Winning region attribute word |

## Verification
A configuration write and an access can land in the same cycle. That cycle is where stale and fresh settings could be mixed. The bench reprograms region 15 from privileged-only to full access in the same cycle as an unprivileged read that hits it. It expects a fault from the old code, and then expects the same read, repeated in the next cycle, to be allowed. Writes that switch the global and background enables are followed immediately by accesses whose verdict depends on them, so a one-cycle lag in either bit shows up as a wrong verdict.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int ATTR_W    = 32;
  // attribute word field positions
  localparam int AT_EN     = 0;
  localparam int AT_SZ_LO  = 1;   // 5 bits
  localparam int AT_SRD_LO = 6;   // 8 bits
  localparam int AT_AP_LO  = 20;  // 3 bits
  localparam int AT_XN     = 23;
  // write port targets
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_ATTR = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  function automatic logic ap_read_ok(input logic [2:0] ap, input logic priv);
    case (ap)
      3'b001, 3'b101:         return priv;
      3'b010, 3'b011,
      3'b110, 3'b111:         return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic logic ap_write_ok(input logic [2:0] ap, input logic priv);
    case (ap)
      3'b001, 3'b010: return priv;
      3'b011:         return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mg_cfg_regs.sv
module mg_cfg_regs
  import mg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_REG = 16,
  parameter int IDX_W   = $clog2(NUM_REG)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_sel,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [ATTR_W-1:0]                 cfg_data,
  output logic [NUM_REG-1:0][ADDR_W-1:0]    base_q,
  output logic [NUM_REG-1:0][ATTR_W-1:0]    attr_q,
  output logic                              en_q,
  output logic                              bg_q
);
  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic sel_here;
    assign sel_here = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (sel_here) begin
        if (cfg_sel == SEL_BASE) base_q[g] <= ADDR_W'(cfg_data);
        if (cfg_sel == SEL_ATTR) attr_q[g] <= cfg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      bg_q <= 1'b0;
    end else if (cfg_we && cfg_sel == SEL_CTL) begin
      en_q <= cfg_data[0];
      bg_q <= cfg_data[1];
    end
  end
endmodule

// File: rtl/mg_region_match.sv
module mg_region_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  input  logic [4:0]        size,
  input  logic [7:0]        srd,
  output logic              hit
);
  // window test on bits above the region size, then subregion cut-out
  function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b,
                                      input logic e, input logic [4:0] sz,
                                      input logic [7:0] m);
    logic       diff;
    logic [2:0] sub;
    diff = 1'b0;
    if (!e || sz < 5'd4) return 1'b0;
    for (int i = 0; i < ADDR_W; i++)
      if (i > int'(sz)) diff = diff | (a[i] ^ b[i]);
    if (diff) return 1'b0;
    if (sz >= 5'd7) begin
      sub = 3'(a >> (sz - 5'd2));
      if (m[sub]) return 1'b0;
    end
    return 1'b1;
  endfunction

  assign hit = region_hit(addr, base, en, size, srd);
endmodule

// File: rtl/mg_prio_pick.sv
module mg_prio_pick #(
  parameter int NUM_REG = 16,
  parameter int IDX_W   = $clog2(NUM_REG)
) (
  input  logic [NUM_REG-1:0] match_vec,
  output logic               win_hit,
  output logic [IDX_W-1:0]   win_idx
);
  // later (higher) indices overwrite earlier ones
  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (match_vec[i]) begin
        win_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mg_guard.sv
module mg_guard
  import mg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_REG = 16,
  localparam int IDX_W  = $clog2(NUM_REG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ATTR_W-1:0]  cfg_data,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_priv,
  input  logic               acc_write,
  input  logic               acc_fetch,
  output logic               res_valid,
  output logic               res_allow,
  output logic               res_fault,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_idx,
  output logic [ATTR_W-1:0]  res_attr
);
  logic [NUM_REG-1:0][ADDR_W-1:0] base_q;
  logic [NUM_REG-1:0][ATTR_W-1:0] attr_q;
  logic                           en_q, bg_q;
  logic [NUM_REG-1:0]             match_vec;
  logic                           win_hit;
  logic [IDX_W-1:0]               win_idx;
  logic [ATTR_W-1:0]              win_attr;
  logic [2:0]                     win_ap;
  logic                           win_xn;
  logic                           hit_c, allow_c;

  mg_cfg_regs #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .base_q(base_q),
    .attr_q(attr_q), .en_q(en_q), .bg_q(bg_q)
  );

  for (genvar g = 0; g < NUM_REG; g++) begin : g_match
    mg_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(acc_addr), .base(base_q[g]),
      .en(attr_q[g][AT_EN]),
      .size(attr_q[g][AT_SZ_LO +: 5]),
      .srd(attr_q[g][AT_SRD_LO +: 8]),
      .hit(match_vec[g])
    );
  end

  mg_prio_pick #(.NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_pick (
    .match_vec(match_vec), .win_hit(win_hit), .win_idx(win_idx)
  );

  assign win_attr = attr_q[win_idx];
  assign win_ap   = win_attr[AT_AP_LO +: 3];
  assign win_xn   = win_attr[AT_XN];
  assign hit_c    = en_q && win_hit;

  always_comb begin
    if (!en_q)          allow_c = 1'b1;
    else if (!win_hit)  allow_c = acc_priv && bg_q;
    else if (acc_fetch) allow_c = ap_read_ok(win_ap, acc_priv) && !win_xn;
    else if (acc_write) allow_c = ap_write_ok(win_ap, acc_priv);
    else                allow_c = ap_read_ok(win_ap, acc_priv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_fault <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= acc_valid;
      res_allow <= acc_valid && allow_c;
      res_fault <= acc_valid && !allow_c;
      res_hit   <= acc_valid && hit_c;
      res_idx   <= (acc_valid && hit_c) ? win_idx : '0;
      res_attr  <= (acc_valid && hit_c) ? win_attr : '0;
    end
  end

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  // R2
  disabled_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !en_q |=> res_allow && !res_fault && !res_hit);
  // R3
  top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && en_q && match_vec[NUM_REG-1] |=> res_idx == IDX_W'(NUM_REG-1));
  // R8
  reserved_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && hit_c && win_ap == 3'b100 |=> res_fault);
  // R9
  xn_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && hit_c && acc_fetch && win_xn |=> res_fault);
  // R10
  bg_unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && en_q && match_vec == '0 && !acc_priv |=> res_fault && !res_hit);
  // R11
  nohit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_idx == '0 && res_attr == '0);
endmodule

// File: tb/mg_guard_bench.sv
`timescale 1ns/1ps
module mg_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_data;
  logic        acc_valid, acc_priv, acc_write, acc_fetch;
  logic [31:0] acc_addr;
  logic        res_valid, res_allow, res_fault, res_hit;
  logic [3:0]  res_idx;
  logic [31:0] res_attr;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] attr_m [16];

  always #2 clk = ~clk;

  mg_guard u_mg_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .res_valid(res_valid), .res_allow(res_allow),
    .res_fault(res_fault), .res_hit(res_hit), .res_idx(res_idx),
    .res_attr(res_attr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        priv, wr, fetch, allow, hit;
    logic [3:0]  idx;
  } vec_t;

  // address, priv, write, fetch -> allow, hit, index
  localparam vec_t VECS [22] = '{
    '{32'h2000_0100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0},   // R7 full access
    '{32'h2000_0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0},   // R7
    '{32'h2000_0100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0},   // R9 execute-never
    '{32'h2000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1},   // R3 R7 read-only read
    '{32'h2000_1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1},   // R7 read-only write
    '{32'h2000_1404, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0},   // R5 falls to region 0
    '{32'h2000_1210, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd15},  // R3 R7 priv only
    '{32'h2000_1210, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15},  // R7
    '{32'h2000_1210, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd15},  // R9 fetch ok
    '{32'h0800_0040, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},   // R9
    '{32'h0800_0040, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},   // R7 priv RO write
    '{32'h0800_0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},   // R7
    '{32'h4000_0010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0},   // R4 too small, R10
    '{32'h4000_0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},   // R10
    '{32'h5000_0004, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},   // R6 mask ignored
    '{32'h5000_0004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},   // R7
    '{32'h6000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},   // R8 reserved
    '{32'h7000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0},   // R4 disabled region
    '{32'h9000_0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},   // R4 base masked, R7 000
    '{32'h9000_01E0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0},   // R5 to background
    '{32'h5000_0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},   // R4 just outside
    '{32'h2000_1400, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0}    // R5 R9
  };

  function automatic logic [31:0] mk(input logic en, input logic [4:0] sz,
                                     input logic [7:0] srd, input logic [2:0] ap,
                                     input logic xn, input logic [2:0] tex,
                                     input logic s, input logic c, input logic b);
    return {8'h00, xn, ap, tex, s, c, b, srd, sz, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic wr(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
    if (sel == 2'd1) attr_m[idx] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input string req, input logic [31:0] a, input logic p,
                     input logic w, input logic f, input logic ex_allow,
                     input logic ex_hit, input logic [3:0] ex_idx);
    acc_valid = 1'b1; acc_addr = a; acc_priv = p; acc_write = w; acc_fetch = f;
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b0;
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " allow"}, 32'(res_allow), 32'(ex_allow));
    chk({req, " fault"}, 32'(res_fault), 32'(!ex_allow));
    chk({req, " hit"}, 32'(res_hit), 32'(ex_hit));
    chk({req, " idx"}, 32'(res_idx), ex_hit ? 32'(ex_idx) : 32'd0);
    chk({req, " attr"}, res_attr, ex_hit ? attr_m[ex_idx] : 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) attr_m[i] = 32'd0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_idx = 4'd0; cfg_data = 32'd0;
    acc_valid = 1'b0; acc_addr = 32'd0; acc_priv = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", 32'(res_valid), 32'd0);
    chk("R1 fault", 32'(res_fault), 32'd0);
    chk("R1 hit", 32'(res_hit), 32'd0);
    chk("R1 attr", res_attr, 32'd0);
    acc("R1 unprogrammed", 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0);

    // R13 programming through the write port
    wr(2'd0, 4'd0, 32'h2000_0000);  wr(2'd1, 4'd0,  mk(1, 16, 8'h00, 3'b011, 1, 3'd1, 0, 1, 0));
    wr(2'd0, 4'd1, 32'h2000_1000);  wr(2'd1, 4'd1,  mk(1, 11, 8'h04, 3'b110, 0, 3'd0, 1, 0, 1));
    wr(2'd0, 4'd15, 32'h2000_1200); wr(2'd1, 4'd15, mk(1, 8, 8'h00, 3'b001, 0, 3'd2, 0, 1, 1));
    wr(2'd0, 4'd3, 32'h0800_0000);  wr(2'd1, 4'd3,  mk(1, 19, 8'h00, 3'b101, 0, 3'd0, 0, 1, 0));
    wr(2'd0, 4'd4, 32'h4000_0010);  wr(2'd1, 4'd4,  mk(1, 3, 8'h00, 3'b011, 0, 3'd0, 0, 0, 0));
    wr(2'd0, 4'd5, 32'h5000_0000);  wr(2'd1, 4'd5,  mk(1, 4, 8'hFF, 3'b010, 0, 3'd4, 1, 0, 0));
    wr(2'd0, 4'd6, 32'h6000_0000);  wr(2'd1, 4'd6,  mk(1, 9, 8'h00, 3'b100, 0, 3'd0, 0, 0, 1));
    wr(2'd0, 4'd7, 32'h7000_0000);  wr(2'd1, 4'd7,  mk(0, 10, 8'h00, 3'b011, 0, 3'd0, 0, 0, 0));
    wr(2'd0, 4'd8, 32'h9000_0123);  wr(2'd1, 4'd8,  mk(1, 7, 8'h80, 3'b000, 0, 3'd0, 0, 0, 0));
    wr(2'd2, 4'd0, 32'h0000_0003);

    for (int v = 0; v < 22; v++)
      acc($sformatf("R7 vector %0d", v), VECS[v].addr, VECS[v].priv, VECS[v].wr,
          VECS[v].fetch, VECS[v].allow, VECS[v].hit, VECS[v].idx);

    // R12 write and access in the same cycle: old permission applies
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_idx = 4'd15;
    cfg_data = mk(1, 8, 8'h00, 3'b011, 0, 3'd2, 0, 1, 1);
    acc_valid = 1'b1; acc_addr = 32'h2000_1210; acc_priv = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R12 same-cycle old code fault", 32'(res_fault), 32'd1);
    chk("R12 same-cycle old attr", res_attr, attr_m[15]);
    attr_m[15] = cfg_data;
    acc("R12 next cycle new code", 32'h2000_1210, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15);

    // R10 background enable cleared
    wr(2'd2, 4'd0, 32'h0000_0001);
    acc("R10 bg off priv", 32'h4000_0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);

    // R2 globally disabled
    wr(2'd2, 4'd0, 32'h0000_0000);
    acc("R2 disabled", 32'h6000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0);

    // R4 full-space region under higher regions, R3
    wr(2'd2, 4'd0, 32'h0000_0003);
    wr(2'd0, 4'd2, 32'h0000_0000);
    wr(2'd1, 4'd2, mk(1, 31, 8'h00, 3'b011, 0, 3'd0, 0, 0, 0));
    acc("R4 full-space", 32'h4000_0010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2);
    acc("R3 region 15 over 2", 32'h2000_1210, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd15);
    acc("R8 region 6 over 2", 32'h6000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule